// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes configuration words for a two-port line driver over a two-wire serial link: a serial clock and a data line, with no select. Both lines are brought into the system clock domain through synchronizers, and data is taken on each rising edge of the serial clock. The received bits are held in a sliding window of one word length. A word is recognised when the window holds the start pair, a stop bit and a full word of fresh bits. It is then committed in one system cycle to whichever ports its mask names, provided its parity holds.

Each port keeps a power mode and a bias code. From these it drives registered decoded enables for the main amplifier, the boost stage and the line-termination mode. The bias output reads zero whenever the main amplifier is off. The block raises a one-cycle pulse for each accepted word and another for each word rejected on parity.

Top module: `cfg_word_rx`

## Requirements
- R1: After synchronous reset, every port reports mode 00, bias 0 and all enables low, and neither pulse output is high.
- R2: A word is 12 bits, B0 first, each sampled on a rising serial clock edge. B0 must be 0, B1 must be 1 and B11 must be 1. B2 is the port-0 select, B3 the port-1 select, B4:B5 the mode (B4 is the MSB), B6..B9 the bias code (B6 is the MSB) and B10 the parity bit.
- R3: An accepted word updates only the ports whose select bit is 1. Mask 11 writes both ports with the same payload, and mask 00 leaves both ports unchanged.
- R4: In modes 10 and 11, the bias output of a written port equals the received 4-bit code.
- R5: The amplifier enable equals the mode MSB. The boost enable is high only in mode 11, and the termination enable is high only in mode 01.
- R6: In modes 00 and 01, the bias output is 0 whatever code the word carried.
- R7: A framed word whose B2..B10 hold an even number of ones is not loaded. It raises parity_err_o for exactly one cycle and never together with frame_ok_o.
- R8: A word with a wrong start pair or stop bit changes no port and raises neither pulse.
- R9: A valid word preceded by arbitrary bits is still found. Each accepted word raises frame_ok_o for exactly one cycle, and the window is emptied after every checked word so that no bit counts twice.
- R10: Changes on the data line while the serial clock does not rise have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| mode_o | output | 4 | Per-port mode, port 0 in [1:0] |
| bias_o | output | 8 | Per-port effective bias code, port 0 in [3:0] |
| amp_en_o | output | 2 | Per-port main amplifier enable |
| boost_en_o | output | 2 | Per-port boost stage enable |
| term_en_o | output | 2 | Per-port line-termination enable |
| frame_ok_o | output | 1 | One-cycle pulse per accepted word |
| parity_err_o | output | 1 | One-cycle pulse per word rejected on parity |

## Verification
On every cycle the assertions check the decode rules that must hold in any state:
- boost implies amplifier;
- termination excludes amplifier;
- bias is zero while the amplifier is off;
- the two pulses never coincide and each lasts one cycle;
- a port holds its mode when it is not written.

Only the directed scenarios can show the rest, because each depends on a whole serial sequence:
- bit order and field positions;
- mask handling;
- parity, start and stop rejection;
- recovery after leading junk bits.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int FRAME_W   = 12;
  localparam int NUM_PORTS = 2;
  localparam int MODE_W    = 2;
  localparam int BIAS_W    = 4;
  // bit positions inside the window; B0 lands in the MSB after a full word
  localparam int POS_START0 = FRAME_W - 1;
  localparam int POS_START1 = FRAME_W - 2;
  localparam int POS_MASK_HI = FRAME_W - 3;
  localparam int POS_MODE_HI = POS_MASK_HI - NUM_PORTS;
  localparam int POS_BIAS_HI = POS_MODE_HI - MODE_W;
  localparam int POS_PAR    = 1;
  localparam int POS_STOP   = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'b00,
    MODE_TERM  = 2'b01,
    MODE_AMP   = 2'b10,
    MODE_BOOST = 2'b11
  } pmode_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0] mask;
    pmode_e               mode;
    logic [BIAS_W-1:0]    bias;
  } payload_t;
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgrx_framer.sv
module cfgrx_framer
  import cfgrx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_stb,
  input  logic     bit_val,
  output logic     frame_ok,
  output logic     parity_err,
  output payload_t payload
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] win_q;
  logic [CNT_W-1:0]   fill_q;
  logic               chk_q;
  logic               framed, par_good;

  assign framed = (fill_q == CNT_W'(FRAME_W)) && !win_q[POS_START0] &&
                  win_q[POS_START1] && win_q[POS_STOP];
  assign par_good = ^win_q[POS_MASK_HI:POS_PAR];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= '0;
      fill_q     <= '0;
      chk_q      <= 1'b0;
      frame_ok   <= 1'b0;
      parity_err <= 1'b0;
      payload    <= '0;
    end else begin
      frame_ok   <= 1'b0;
      parity_err <= 1'b0;
      chk_q      <= bit_stb;
      if (chk_q && framed) begin
        win_q  <= '0;
        fill_q <= '0;
        if (par_good) begin
          frame_ok <= 1'b1;
          payload  <= win_q[POS_MASK_HI:POS_PAR+1];
        end else begin
          parity_err <= 1'b1;
        end
      end else if (bit_stb) begin
        win_q <= {win_q[FRAME_W-2:0], bit_val};
        if (fill_q != CNT_W'(FRAME_W)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && parity_err)); // R7
  AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    parity_err |=> !parity_err); // R7
endmodule

// File: rtl/cfgrx_port.sv
module cfgrx_port
  import cfgrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  pmode_e            mode_i,
  input  logic [BIAS_W-1:0] bias_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [BIAS_W-1:0] bias_o,
  output logic              amp_en,
  output logic              boost_en,
  output logic              term_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o   <= '0;
      bias_o   <= '0;
      amp_en   <= 1'b0;
      boost_en <= 1'b0;
      term_en  <= 1'b0;
    end else if (wr) begin
      mode_o   <= mode_i;
      amp_en   <= mode_i[MODE_W-1];
      boost_en <= (mode_i == MODE_BOOST);
      term_en  <= (mode_i == MODE_TERM);
      bias_o   <= mode_i[MODE_W-1] ? bias_i : '0;
    end
  end

  AST_BOOST_NEEDS_AMP: assert property (@(posedge clk) disable iff (rst)
    boost_en |-> amp_en); // R5
  AST_TERM_NOT_AMP: assert property (@(posedge clk) disable iff (rst)
    !(term_en && amp_en)); // R5
  AST_BIAS_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    !amp_en |-> (bias_o == '0)); // R6
  AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mode_o)); // R3
endmodule

// File: rtl/cfg_word_rx.sv
module cfg_word_rx
  import cfgrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sclk_in,
  input  logic                        sdata_in,
  output logic [NUM_PORTS*MODE_W-1:0] mode_o,
  output logic [NUM_PORTS*BIAS_W-1:0] bias_o,
  output logic [NUM_PORTS-1:0]        amp_en_o,
  output logic [NUM_PORTS-1:0]        boost_en_o,
  output logic [NUM_PORTS-1:0]        term_en_o,
  output logic                        frame_ok_o,
  output logic                        parity_err_o
);
  logic [1:0] line_s;
  logic       sclk_d;
  logic       rise;
  payload_t   pay;

  cfgrx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .async_i({sclk_in, sdata_in}), .sync_o(line_s));

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= line_s[1];
  end
  assign rise = line_s[1] && !sclk_d;

  cfgrx_framer u_framer (
    .clk(clk), .rst(rst), .bit_stb(rise), .bit_val(line_s[0]),
    .frame_ok(frame_ok_o), .parity_err(parity_err_o), .payload(pay));

  // mask MSB (B2) selects port 0
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      cfgrx_port u_port (
        .clk(clk), .rst(rst),
        .wr(frame_ok_o && pay.mask[NUM_PORTS-1-p]),
        .mode_i(pay.mode), .bias_i(pay.bias),
        .mode_o(mode_o[p*MODE_W +: MODE_W]),
        .bias_o(bias_o[p*BIAS_W +: BIAS_W]),
        .amp_en(amp_en_o[p]), .boost_en(boost_en_o[p]), .term_en(term_en_o[p]));
    end
  endgenerate
endmodule

// File: tb/cfg_word_rx_tb.sv
module cfg_word_rx_tb;
  localparam int CLK_NS = 10;
  localparam int HALF_SCLK = 8;

  logic clk = 0, rst = 1, sclk = 0, sdata = 0;
  logic [3:0] mode; logic [7:0] bias;
  logic [1:0] amp, boost, term;
  logic ok, perr;
  int n_chk = 0, n_fail = 0, n_ok = 0, n_perr = 0;

  always #(CLK_NS/2) clk = ~clk;

  cfg_word_rx u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdata),
    .mode_o(mode), .bias_o(bias), .amp_en_o(amp), .boost_en_o(boost),
    .term_en_o(term), .frame_ok_o(ok), .parity_err_o(perr));

  always @(negedge clk) begin
    if (ok) n_ok++;
    if (perr) n_perr++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(logic p0, logic p1, logic [1:0] m,
                                     logic [3:0] b, logic good);
    logic [7:0] pl = {p0, p1, m, b};
    logic par = ~(^pl);
    if (!good) par = ~par;
    return {1'b0, 1'b1, pl, par, 1'b1};
  endfunction

  task automatic send_bit(logic v);
    sdata = v;
    repeat (HALF_SCLK) @(negedge clk);
    sclk = 1;
    repeat (HALF_SCLK) @(negedge clk);
    sclk = 0;
  endtask

  task automatic send_word(logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_port(string req, int p, int m, int b, int a, int bo, int t);
    chk(req, mode[p*2 +: 2], m);
    chk(req, bias[p*4 +: 4], b);
    chk(req, amp[p], a);
    chk(req, boost[p], bo);
    chk(req, term[p], t);
  endtask

  task automatic t_reset;
    chk_port("R1", 0, 0, 0, 0, 0, 0);
    chk_port("R1", 1, 0, 0, 0, 0, 0);
    chk("R1", {ok, perr}, 0);
  endtask

  task automatic t_port0;
    send_word(mk(1, 0, 2'b10, 4'h9, 1));
    chk_port("R2 R4", 0, 2, 9, 1, 0, 0);
    chk_port("R3", 1, 0, 0, 0, 0, 0);
    chk("R9", n_ok, 1);
  endtask

  task automatic t_port1;
    send_word(mk(0, 1, 2'b11, 4'hF, 1));
    chk_port("R5", 1, 3, 15, 1, 1, 0);
    chk_port("R3", 0, 2, 9, 1, 0, 0);
  endtask

  task automatic t_both_term;
    send_word(mk(1, 1, 2'b01, 4'h7, 1));
    chk_port("R6", 0, 1, 0, 0, 0, 1);
    chk_port("R6", 1, 1, 0, 0, 0, 1);
  endtask

  task automatic t_mask_none;
    send_word(mk(0, 0, 2'b11, 4'h5, 1));
    chk_port("R3", 0, 1, 0, 0, 0, 1);
    chk_port("R3", 1, 1, 0, 0, 0, 1);
  endtask

  task automatic t_parity;
    int e = n_perr, o = n_ok;
    send_word(mk(1, 1, 2'b10, 4'h3, 0));
    chk_port("R7", 0, 1, 0, 0, 0, 1);
    chk("R7", n_perr, e + 1);
    chk("R7", n_ok, o);
  endtask

  task automatic t_badframe;
    int o = n_ok, e = n_perr;
    logic [11:0] w = mk(1, 1, 2'b10, 4'h3, 1);
    w[0] = 0;
    send_word(w);
    w = mk(1, 1, 2'b10, 4'h3, 1);
    w[11] = 1;
    send_word(w);
    chk_port("R8", 1, 1, 0, 0, 0, 1);
    chk("R8", n_ok, o);
    chk("R8", n_perr, e);
  endtask

  task automatic t_junk;
    int o;
    for (int i = 0; i < 11; i++) send_bit(1'b1);
    o = n_ok;
    send_word(mk(1, 1, 2'b11, 4'hA, 1));
    chk_port("R9", 0, 3, 10, 1, 1, 0);
    chk("R9", n_ok, o + 1);
  endtask

  task automatic t_no_edge;
    for (int i = 0; i < 20; i++) begin
      sdata = ~sdata;
      repeat (3) @(negedge clk);
    end
    sclk = 1;
    for (int i = 0; i < 10; i++) begin
      sdata = ~sdata;
      repeat (3) @(negedge clk);
    end
    sclk = 0;
    repeat (6) @(negedge clk);
    send_word(mk(1, 0, 2'b00, 4'hC, 1));
    chk_port("R10 R6", 0, 0, 0, 0, 0, 0);
    chk_port("R10", 1, 3, 10, 1, 1, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_port0();
    t_port1();
    t_both_term();
    t_mask_none();
    t_parity();
    t_badframe();
    t_junk();
    t_no_edge();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule